// File: doc/BRIEF.md
# Power-Domain Register Access Proxy

This block lets a host reach a register that sits behind a power gate without first waking the gate's domain in software. The host sees two 32-bit registers, a data word and a control word. It puts the target offset, the access direction and a power-domain code into the control word. When the host sets the start flag in that word, the proxy raises the wake request of the chosen domain and waits for its acknowledge. It then makes one 32-bit access on a simple internal register bus, drops the wake request and clears the start flag.

For a write, the host loads the data word first and then starts the access. For a read, the proxy puts the fetched value into the data word before the start flag clears. The host polls the start flag to learn that the access is complete. The domain acknowledges pass through a synchronizer of parameterised depth before the proxy uses them.

Top module: `gated_reg_proxy`

## Requirements
- R1: After reset the data word and the control word read as zero, no wake request is raised and the internal strobe is low.
- R2: The data word is at host address 0xF00 and the control word at 0xF04. A control write with bit 31 clear latches offset (bits OFS_W-1:0), direction (bit 24) and domain (bits 29:28). It starts nothing, and reading it back returns these fields.
- R3: A control write with bit 31 set launches an access. The wake request has bit 0 for blitter, bit 1 for render and bit 2 for media. Domain code 0 raises bit 0, code 1 raises bit 1, code 2 raises bit 2, and code 3 raises all three together.
- R4: The internal strobe stays low until every requested acknowledge has been seen high.
- R5: Each access gives exactly one single-cycle strobe. The address equals the latched offset and write enable equals direction 0 (write). On a write, the write data equals the data word.
- R6: On a read (direction 1), the read data present one cycle after the strobe is stored in the data word before the start flag clears.
- R7: The start flag clears when the access finishes, and in that same cycle the wake request drops to zero.
- R8: While the start flag is set, host writes to either register have no effect, and a read of the control word shows bit 31 high.
- R9: The wake request stays constant from launch until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host access is a write |
| host_addr | input | HADDR_W | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from address |
| wake_req | output | 3 | Domain wake requests (blitter, render, media) |
| wake_ack | input | 3 | Domain power acknowledges |
| ib_stb | output | 1 | Internal bus access strobe |
| ib_we | output | 1 | Internal bus write enable |
| ib_addr | output | OFS_W | Internal bus register offset |
| ib_wdata | output | 32 | Internal bus write data |
| ib_rdata | input | 32 | Internal bus read data, valid one cycle after strobe |

## Verification
On every cycle the assertions check several properties. They check that an idle proxy raises no wake request and no strobe. They check that a strobe only happens with a domain awake and never lasts two cycles, and that the wake request holds steady and drops as the flag clears. They also check that the latched fields hold while busy. Only the bench scenarios can show the data values. These are the mapping of each domain code to its request bits, that written data lands at the right offset, and that read results appear in the data word. The bench scenarios also show that host writes made during a stalled acknowledge leave both registers untouched.

// File: rtl/grp_pkg.sv
package grp_pkg;
   localparam int NUM_DOM  = 3;
   localparam int GO_BIT   = 31;
   localparam int DOM_LSB  = 28;
   localparam int OP_BIT   = 24;

   typedef enum logic [1:0] {
      DOM_BLT = 2'd0,
      DOM_RND = 2'd1,
      DOM_MED = 2'd2,
      DOM_ANY = 2'd3
   } dom_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAKE,
      ST_ISSUE,
      ST_CAPT
   } seq_st_e;

   function automatic logic [NUM_DOM-1:0] dom_to_mask(dom_e d);
      logic [NUM_DOM-1:0] m;
      case (d)
         DOM_BLT: m = 3'b001;
         DOM_RND: m = 3'b010;
         DOM_MED: m = 3'b100;
         default: m = 3'b111;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/grp_host_regs.sv
module grp_host_regs
   import grp_pkg::*;
#(
   parameter int HADDR_W   = 12,
   parameter int OFS_W     = 16,
   parameter logic [HADDR_W-1:0] DATA_ADDR = 'hF00,
   parameter logic [HADDR_W-1:0] CTRL_ADDR = 'hF04
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_sel,
   input  logic               host_wr,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   input  logic               done,
   input  logic               cap_en,
   input  logic [31:0]        cap_data,
   output logic               launch,
   output logic               busy,
   output logic [OFS_W-1:0]   ofs,
   output dom_e               dom,
   output logic               op_rd,
   output logic [31:0]        data_q
);
   logic hit_data, hit_ctrl, wr_data, wr_ctrl;

   assign hit_data = host_sel && (host_addr == DATA_ADDR);
   assign hit_ctrl = host_sel && (host_addr == CTRL_ADDR);
   assign wr_data  = hit_data && host_wr && !busy;
   assign wr_ctrl  = hit_ctrl && host_wr && !busy;
   assign launch   = wr_ctrl && host_wdata[GO_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         ofs    <= '0;
         dom    <= DOM_BLT;
         op_rd  <= 1'b0;
         data_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ofs   <= host_wdata[OFS_W-1:0];
            dom   <= dom_e'(host_wdata[DOM_LSB+1:DOM_LSB]);
            op_rd <= host_wdata[OP_BIT];
            busy  <= host_wdata[GO_BIT];
         end else if (done) begin
            busy  <= 1'b0;
         end
         if (wr_data)
            data_q <= host_wdata;
         else if (cap_en)
            data_q <= cap_data;
      end
   end

   always_comb begin
      host_rdata = '0;
      if (hit_ctrl) begin
         host_rdata[OFS_W-1:0]           = ofs;
         host_rdata[OP_BIT]              = op_rd;
         host_rdata[DOM_LSB+1:DOM_LSB]   = dom;
         host_rdata[GO_BIT]              = busy;
      end else if (hit_data) begin
         host_rdata = data_q;
      end
   end

   assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(ofs) && $stable(dom) && $stable(op_rd)))
      else $error("control fields changed while busy");

endmodule

// File: rtl/grp_wake_ctrl.sv
module grp_wake_ctrl
   import grp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  dom_e               dom,
   input  logic [NUM_DOM-1:0] wake_ack,
   output logic [NUM_DOM-1:0] wake_req,
   output logic               all_ok
);
   logic [NUM_DOM-1:0] mask;
   logic [NUM_DOM-1:0] ack_s;

   assign mask     = dom_to_mask(dom);
   assign wake_req = active ? mask : '0;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ack_s = wake_ack;
      end else begin : g_sync
         for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
               if (!rst_n) chain <= '0;
               else if (SYNC_STAGES == 1) chain <= wake_ack[d];
               else chain <= {chain[SYNC_STAGES-2:0], wake_ack[d]};
            end
            assign ack_s[d] = chain[SYNC_STAGES-1];
         end
      end
   endgenerate

   assign all_ok = active && ((ack_s & mask) == mask);

   assert_req_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(wake_req))
      else $error("wake request changed during access");

endmodule

// File: rtl/grp_seq.sv
module grp_seq
   import grp_pkg::*;
#(
   parameter int OFS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             op_rd,
   input  logic [OFS_W-1:0] ofs,
   input  logic [31:0]      data_q,
   input  logic             all_ok,
   input  logic [31:0]      ib_rdata,
   output logic             active,
   output logic             done,
   output logic             cap_en,
   output logic [31:0]      cap_data,
   output logic             ib_stb,
   output logic             ib_we,
   output logic [OFS_W-1:0] ib_addr,
   output logic [31:0]      ib_wdata
);
   seq_st_e st, st_nx;

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE:  if (launch) st_nx = ST_WAKE;
         ST_WAKE:  if (all_ok) st_nx = ST_ISSUE;
         ST_ISSUE: st_nx = op_rd ? ST_CAPT : ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   assign active   = (st != ST_IDLE);
   assign ib_stb   = (st == ST_ISSUE);
   assign ib_we    = !op_rd;
   assign ib_addr  = ofs;
   assign ib_wdata = data_q;
   assign cap_en   = (st == ST_CAPT);
   assign cap_data = ib_rdata;
   assign done     = (ib_stb && !op_rd) || cap_en;

   assert_strobe_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ib_stb |-> $past(all_ok))
      else $error("strobe without acknowledge");

   assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ib_stb |=> !ib_stb)
      else $error("strobe longer than one cycle");

   assert_read_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ib_stb && !ib_we) |=> done)
      else $error("read not captured after strobe");

endmodule

// File: rtl/gated_reg_proxy.sv
module gated_reg_proxy
   import grp_pkg::*;
#(
   parameter int HADDR_W     = 12,
   parameter int OFS_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter logic [HADDR_W-1:0] DATA_ADDR = 'hF00,
   parameter logic [HADDR_W-1:0] CTRL_ADDR = 'hF04
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_sel,
   input  logic               host_wr,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   output logic [NUM_DOM-1:0] wake_req,
   input  logic [NUM_DOM-1:0] wake_ack,
   output logic               ib_stb,
   output logic               ib_we,
   output logic [OFS_W-1:0]   ib_addr,
   output logic [31:0]        ib_wdata,
   input  logic [31:0]        ib_rdata
);
   initial begin
      assert (OFS_W >= 2 && OFS_W <= OP_BIT) else $error("OFS_W must be 2..24");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES must be 0..4");
      assert (DATA_ADDR != CTRL_ADDR) else $error("register addresses collide");
   end

   logic             launch, busy, op_rd, done, cap_en, active, all_ok;
   logic [OFS_W-1:0] ofs;
   logic [31:0]      data_q, cap_data;
   dom_e             dom;

   grp_host_regs #(
      .HADDR_W(HADDR_W), .OFS_W(OFS_W),
      .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) u_regs (
      .clk, .rst_n, .host_sel, .host_wr, .host_addr, .host_wdata, .host_rdata,
      .done, .cap_en, .cap_data, .launch, .busy, .ofs, .dom, .op_rd, .data_q
   );

   grp_wake_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk, .rst_n, .active, .dom, .wake_ack, .wake_req, .all_ok
   );

   grp_seq #(.OFS_W(OFS_W)) u_seq (
      .clk, .rst_n, .launch, .op_rd, .ofs, .data_q, .all_ok, .ib_rdata,
      .active, .done, .cap_en, .cap_data, .ib_stb, .ib_we, .ib_addr, .ib_wdata
   );

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (wake_req == '0 && !ib_stb))
      else $error("activity while idle");

   assert_stb_awake_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ib_stb |-> (wake_req != '0))
      else $error("strobe with no domain requested");

   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (wake_req == '0))
      else $error("wake request held after completion");

endmodule

// File: tb/gated_reg_proxy_bench.sv
module gated_reg_proxy_bench;
   localparam int HADDR_W = 12;
   localparam int OFS_W   = 16;
   localparam logic [11:0] A_DATA = 12'hF00;
   localparam logic [11:0] A_CTRL = 12'hF04;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0, host_wr = 1'b0;
   logic [11:0] host_addr = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic [2:0]  wake_req, wake_ack;
   logic        ib_stb, ib_we;
   logic [15:0] ib_addr;
   logic [31:0] ib_wdata;
   logic [31:0] ib_rdata = '0;

   always #5 clk = ~clk;

   gated_reg_proxy u_gated_reg_proxy (
      .clk, .rst_n, .host_sel, .host_wr, .host_addr, .host_wdata, .host_rdata,
      .wake_req, .wake_ack, .ib_stb, .ib_we, .ib_addr, .ib_wdata, .ib_rdata
   );

   int checks = 0;
   int errors = 0;

   // domain power stub: each domain acknowledges after its own delay
   logic [2:0] ack_q = '0, hold = '0;
   int         dcnt [3];
   assign wake_ack = ack_q;
   always @(posedge clk) begin
      for (int d = 0; d < 3; d++) begin
         if (!wake_req[d]) begin
            ack_q[d] <= 1'b0; dcnt[d] <= 0;
         end else if (hold[d]) begin
            ack_q[d] <= 1'b0;
         end else if (dcnt[d] >= 2 * d + 1) begin
            ack_q[d] <= 1'b1;
         end else begin
            dcnt[d] <= dcnt[d] + 1;
         end
      end
   end

   // register file stub and its independent model
   logic [31:0] mem [256];
   logic [31:0] model [256];
   int          stb_cnt = 0;
   logic [15:0] last_addr;
   logic        last_we;
   logic [31:0] last_wdata;
   logic [2:0]  req_at_stb, ack_at_stb;
   initial for (int i = 0; i < 256; i++) begin
      mem[i]   = 32'h9E37_79B9 * i + 32'h1357;
      model[i] = 32'h9E37_79B9 * i + 32'h1357;
   end
   always @(posedge clk) begin
      if (ib_stb) begin
         stb_cnt    <= stb_cnt + 1;
         last_addr  <= ib_addr;
         last_we    <= ib_we;
         last_wdata <= ib_wdata;
         req_at_stb <= wake_req;
         ack_at_stb <= wake_ack;
         if (ib_we) mem[ib_addr[7:0]] <= ib_wdata;
         else       ib_rdata <= mem[ib_addr[7:0]];
      end
   end

   function automatic logic [2:0] exp_mask(logic [1:0] d);
      return (d == 2'd3) ? 3'b111 : (3'b001 << d);
   endfunction

   function automatic logic [31:0] ctrl_word(logic go, logic [1:0] d, logic rd, logic [15:0] o);
      return {go, 1'b0, d, 3'b000, rd, 8'h00, o};
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [11:0] a, input logic [31:0] v);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = v;
      @(posedge clk); #1;
      host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic hread(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
      #1 v = host_rdata;
      host_sel = 1'b0;
   endtask

   task automatic wait_done(output logic ok);
      logic [31:0] r;
      ok = 1'b0;
      for (int n = 0; n < 300; n++) begin
         hread(A_CTRL, r);
         if (!r[31]) begin ok = 1'b1; break; end
      end
   endtask

   task automatic access(input logic [1:0] d, input logic rd, input logic [15:0] o, input logic [31:0] v);
      logic [31:0] r;
      logic        ok;
      int          s0;
      if (!rd) hwrite(A_DATA, v);
      hwrite(A_CTRL, ctrl_word(1'b0, d, rd, o));
      hread(A_CTRL, r);
      chk(r == ctrl_word(1'b0, d, rd, o), "R2 fields", r, ctrl_word(1'b0, d, rd, o));
      s0 = stb_cnt;
      hwrite(A_CTRL, ctrl_word(1'b1, d, rd, o));
      wait_done(ok);
      chk(ok, "R7 flag clears", {31'd0, ok}, 32'd1);
      chk(wake_req == 3'b000, "R7 release", {29'd0, wake_req}, 32'd0);
      chk(stb_cnt == s0 + 1, "R5 one strobe", stb_cnt - s0, 32'd1);
      chk(req_at_stb == exp_mask(d), "R3 domain mask", {29'd0, req_at_stb}, {29'd0, exp_mask(d)});
      chk((ack_at_stb & exp_mask(d)) == exp_mask(d), "R4 acks present", {29'd0, ack_at_stb}, {29'd0, exp_mask(d)});
      chk(last_addr == o && last_we == !rd, "R5 addr/we", {last_we, 15'd0, last_addr}, {!rd, 15'd0, o});
      if (!rd) begin
         chk(last_wdata == v, "R5 wdata", last_wdata, v);
         model[o[7:0]] = v;
      end else begin
         hread(A_DATA, r);
         chk(r == model[o[7:0]], "R6 read result", r, model[o[7:0]]);
      end
   endtask

   initial begin
      logic [31:0] r;
      logic        ok;
      int          s0;
      void'($urandom(32'h5EED_0042));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      hread(A_DATA, r);
      chk(r == 0, "R1 data reset", r, 0);
      hread(A_CTRL, r);
      chk(r == 0, "R1 ctrl reset", r, 0);
      chk(wake_req == 0 && !ib_stb, "R1 quiet", {28'd0, ib_stb, wake_req}, 0);

      // R2 latch without start
      s0 = stb_cnt;
      hwrite(A_CTRL, ctrl_word(1'b0, 2'd2, 1'b1, 16'h0033));
      repeat (8) @(negedge clk);
      chk(wake_req == 0, "R2 no wake", {29'd0, wake_req}, 0);
      chk(stb_cnt == s0, "R2 no strobe", stb_cnt - s0, 0);
      hread(A_CTRL, r);
      chk(r == ctrl_word(1'b0, 2'd2, 1'b1, 16'h0033), "R2 readback", r, ctrl_word(1'b0, 2'd2, 1'b1, 16'h0033));

      // R3 every domain code, both directions
      for (int d = 0; d < 4; d++) begin
         access(d[1:0], 1'b0, 16'h0010 + 16'(d), 32'hC0DE_0000 + d);
         access(d[1:0], 1'b1, 16'h0010 + 16'(d), 32'h0);
      end

      // R4/R8 stalled acknowledge: writes during busy are ignored
      hwrite(A_DATA, 32'hFEED_BEEF);
      hold = 3'b010;
      s0 = stb_cnt;
      hwrite(A_CTRL, ctrl_word(1'b1, 2'd3, 1'b0, 16'h0077));
      repeat (20) @(negedge clk);
      chk(stb_cnt == s0, "R4 no strobe while ack low", stb_cnt - s0, 0);
      chk(wake_req == 3'b111, "R9 request held", {29'd0, wake_req}, 32'h7);
      hwrite(A_DATA, 32'h1111_2222);
      hwrite(A_CTRL, ctrl_word(1'b0, 2'd0, 1'b1, 16'h0005));
      hread(A_CTRL, r);
      chk(r == ctrl_word(1'b1, 2'd3, 1'b0, 16'h0077), "R8 ctrl busy view", r, ctrl_word(1'b1, 2'd3, 1'b0, 16'h0077));
      hread(A_DATA, r);
      chk(r == 32'hFEED_BEEF, "R8 data unchanged", r, 32'hFEED_BEEF);
      hold = 3'b000;
      wait_done(ok);
      chk(ok, "R7 flag clears after stall", {31'd0, ok}, 1);
      chk(last_wdata == 32'hFEED_BEEF && last_addr == 16'h0077, "R8 original write used", last_wdata, 32'hFEED_BEEF);
      model[8'h77] = 32'hFEED_BEEF;
      hread(A_DATA, r);
      chk(r == 32'hFEED_BEEF, "R6 write keeps data word", r, 32'hFEED_BEEF);

      // boundary offsets
      access(2'd1, 1'b0, 16'hFFFF, 32'hA5A5_5A5A);
      access(2'd1, 1'b1, 16'hFFFF, 32'h0);
      access(2'd0, 1'b1, 16'h0000, 32'h0);

      // constrained random mix
      for (int k = 0; k < 40; k++) begin
         logic [1:0]  rd_d;
         logic        rd_o;
         logic [15:0] rd_a;
         rd_d = 2'($urandom_range(0, 3));
         rd_o = 1'($urandom_range(0, 1));
         rd_a = {8'h00, 8'($urandom_range(0, 255))};
         access(rd_d, rd_o, rd_a, $urandom);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule